// File: doc/BRIEF.md
# Indirect Register Bus Bridge

This block lets a host reach a 32-bit internal register bus through three 64-bit memory-mapped words. The host packs each access into one write to a control word: a 2-bit opcode in the top bits, a 13-bit byte address for the target register, and 32 bits of write data. The bridge then performs exactly one request/acknowledge transaction on its internal port. The host polls a status word until a completion flag appears. For reads, it takes the returned data from the low half of that same word.

A third word is a constant that describes an attached serial peripheral controller: bit order, word width, number of chip selects, clock polarity and phase, and an identifier. Synthesis parameters set these values, and host writes cannot change them. Internal registers sit on a 4-byte stride, so the low two address bits are passed through unchanged.

Top module: `ireg_bridge`

## Requirements
- R1: A read at offset 0x8 returns the descriptor word. Its fields are: bit 1 shift order (0 = MSB first, 1 = LSB first), bits 7:2 word width, bits 13:8 chip-select count, bit 14 clock polarity, bit 15 clock phase, bits 47:32 peripheral identifier. All other bits are zero.
- R2: Reads at any offset other than 0x8 and 0x18, including the control word at 0x10, return zero.
- R3: A write to offset 0x10 with bits 63:62 = 1 (read) or 2 (write) launches exactly one internal transaction. Its address comes from bits 44:32, and for a write its data comes from bits 31:0; bus_we is high only for opcode 2.
- R4: While the request is unacknowledged, bus_req, bus_addr, bus_we and bus_wdata hold steady.
- R5: Status bit 32 reads 0 from the cycle after a launching command until the acknowledge. It reads 1 from the cycle after the acknowledge.
- R6: Status bits 31:0 change only when a read completes, and then take the target's data. A completed write leaves them as they were.
- R7: Opcode 0 (no operation) and the unused opcode 3 launch nothing and leave the status word unchanged.
- R8: A control write that arrives while a transaction is outstanding is dropped. It causes no second internal access, and the outstanding access completes normally.
- R9: Host writes to offsets 0x8 and 0x18 have no effect on the values read there.
- R10: After reset the status word is zero and no request is raised.
- R11: With a target that acknowledges within a few cycles, completion is visible within ten host polls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Host write strobe |
| csr_addr | input | 8 | Host byte offset |
| csr_wdata | input | 64 | Host write data |
| csr_rdata | output | 64 | Host read data for csr_addr, combinational |
| bus_req | output | 1 | Internal request, held until acknowledge |
| bus_we | output | 1 | Internal write enable |
| bus_addr | output | 13 | Internal register byte address |
| bus_wdata | output | 32 | Internal write data |
| bus_ack | input | 1 | Internal acknowledge, one cycle |
| bus_rdata | input | 32 | Internal read data, valid with bus_ack |

## Verification
The bench drives forty random mixes of reads and writes to random word addresses. The target model acknowledges after a random delay of zero to three cycles. Comparing against a shadow copy of the target memory shows whether address and data fields are taken from the right bit positions, and whether read data is captured only on read completions. Directed cases separate the remaining behaviours. A slow target with a second command arriving early checks that the busy drop loses nothing and adds no access. Opcodes 0 and 3 issued after a completion show that the status word is left alone. Writes to the read-only words must leave their values unchanged.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
    localparam int CSR_AW = 8;
    localparam int CSR_DW = 64;

    localparam logic [CSR_AW-1:0] OFF_DESC = 8'h08;
    localparam logic [CSR_AW-1:0] OFF_CMD  = 8'h10;
    localparam logic [CSR_AW-1:0] OFF_STAT = 8'h18;

    localparam int CMD_OP_HI   = 63;
    localparam int CMD_OP_LO   = 62;
    localparam int CMD_ADDR_LO = 32;
    localparam int STAT_DONE   = 32;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;
endpackage

// File: rtl/ireg_desc_word.sv
module ireg_desc_word #(
    parameter bit          LSB_FIRST = 1'b0,
    parameter int          WORD_BITS = 32,
    parameter int          NUM_SEL   = 1,
    parameter bit          CPOL      = 1'b0,
    parameter bit          CPHA      = 1'b0,
    parameter logic [15:0] PERIPH_ID = 16'h3A5C
) (
    output logic [63:0] desc
);
    localparam logic [5:0] WIDTH_F = WORD_BITS[5:0];
    localparam logic [5:0] SEL_F   = NUM_SEL[5:0];

    always_comb begin
        desc        = '0;
        desc[1]     = LSB_FIRST;
        desc[7:2]   = WIDTH_F;
        desc[13:8]  = SEL_F;
        desc[14]    = CPOL;
        desc[15]    = CPHA;
        desc[47:32] = PERIPH_ID;
    end
endmodule

// File: rtl/ireg_cmd_engine.sv
module ireg_cmd_engine
    import ireg_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } eng_t;

    eng_t st_q, st_d;
    logic launch;

    always_comb begin
        st_d   = st_q;
        launch = cmd_wr && !st_q.busy &&
                 (cmd_op == OP_READ || cmd_op == OP_WRITE);
        if (st_q.busy) begin
            if (bus_ack) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                if (!st_q.we) st_d.rdata = bus_rdata;
            end
        end else if (launch) begin
            st_d.busy  = 1'b1;
            st_d.done  = 1'b0;
            st_d.we    = (cmd_op == OP_WRITE);
            st_d.addr  = cmd_addr;
            st_d.wdata = cmd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done      = st_q.done;
    assign rdata     = st_q.rdata;
    assign bus_req   = st_q.busy;
    assign bus_we    = st_q.we;
    assign bus_addr  = st_q.addr;
    assign bus_wdata = st_q.wdata;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_we) && $stable(bus_wdata)));
    // R5
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (done && !bus_req));
    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !bus_req && (cmd_op == OP_READ || cmd_op == OP_WRITE))
        |=> (!done && bus_req));
    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_ack && !bus_we) |=> $stable(rdata));
    // R7
    idle_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && cmd_wr && (cmd_op == OP_IDLE || cmd_op == OP_RSVD))
        |=> (!bus_req && $stable(done)));
    // R8
    no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && cmd_wr) |=> (bus_req && $stable(bus_addr)));
endmodule

// File: rtl/ireg_read_mux.sv
module ireg_read_mux
    import ireg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [CSR_AW-1:0] addr,
    input  logic [63:0]       desc,
    input  logic              done,
    input  logic [DATA_W-1:0] rdata,
    output logic [CSR_DW-1:0] q
);
    always_comb begin
        q = '0;
        unique case (addr)
            OFF_DESC: q = desc;
            OFF_STAT: begin
                q[DATA_W-1:0] = rdata;
                q[STAT_DONE]  = done;
            end
            default:  q = '0;
        endcase
    end
endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
    import ireg_pkg::*;
#(
    parameter int          ADDR_W    = 13,
    parameter int          DATA_W    = 32,
    parameter bit          LSB_FIRST = 1'b0,
    parameter int          WORD_BITS = 32,
    parameter int          NUM_SEL   = 1,
    parameter bit          CPOL      = 1'b0,
    parameter bit          CPHA      = 1'b0,
    parameter logic [15:0] PERIPH_ID = 16'h3A5C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [7:0]        csr_addr,
    input  logic [63:0]       csr_wdata,
    output logic [63:0]       csr_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int ADDR_HI = CMD_ADDR_LO + ADDR_W - 1;

    logic [63:0]       desc;
    logic              done;
    logic [DATA_W-1:0] rdata;
    logic              cmd_wr;
    logic              unused_bits;

    assign cmd_wr      = csr_wr && (csr_addr == OFF_CMD);
    assign unused_bits = ^csr_wdata[CMD_OP_LO-1:ADDR_HI+1];

    ireg_desc_word #(
        .LSB_FIRST(LSB_FIRST), .WORD_BITS(WORD_BITS), .NUM_SEL(NUM_SEL),
        .CPOL(CPOL), .CPHA(CPHA), .PERIPH_ID(PERIPH_ID)
    ) u_desc (
        .desc(desc)
    );

    ireg_cmd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_op   (csr_wdata[CMD_OP_HI:CMD_OP_LO]),
        .cmd_addr (csr_wdata[ADDR_HI:CMD_ADDR_LO]),
        .cmd_data (csr_wdata[DATA_W-1:0]),
        .done     (done),
        .rdata    (rdata),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_ack  (bus_ack),
        .bus_rdata(bus_rdata)
    );

    ireg_read_mux #(.DATA_W(DATA_W)) u_mux (
        .addr (csr_addr),
        .desc (desc),
        .done (done),
        .rdata(rdata),
        .q    (csr_rdata)
    );

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!bus_req && !done));
endmodule

// File: tb/ireg_bridge_test.sv
module ireg_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [7:0]  csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        bus_req, bus_we;
    logic [12:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int errors = 0;
    int txn = 0;
    int ack_delay = 0;
    int wait_cnt = 0;
    bit held = 0;
    logic [12:0] h_addr;
    logic        h_we;
    logic [31:0] h_wdata;
    logic [31:0] tmem [0:2047];
    logic [31:0] emem [0:2047];
    logic [31:0] exp_rd = '0;

    always #10 clk = ~clk;

    ireg_bridge uut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    function automatic logic [63:0] exp_desc();
        logic [63:0] v = '0;
        v = v | (64'(16'h3A5C) << 32);
        v = v | (64'(32) << 2);
        v = v | (64'(1) << 8);
        return v;
    endfunction

    function automatic logic [63:0] cmd(input logic [1:0] op,
                                        input logic [12:0] a,
                                        input logic [31:0] d);
        return (64'(op) << 62) | (64'(a) << 32) | 64'(d);
    endfunction

    task automatic check(input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // target model, acts away from the rising edge
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0; wait_cnt = 0; held = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0; wait_cnt = 0;
        end else if (bus_req) begin
            if (held) begin
                checks++;
                if (bus_addr !== h_addr || bus_we !== h_we || bus_wdata !== h_wdata) begin
                    errors++;
                    $display("FAIL R4 actual %h/%b/%h expected %h/%b/%h",
                             bus_addr, bus_we, bus_wdata, h_addr, h_we, h_wdata);
                end
            end
            held = 1; h_addr = bus_addr; h_we = bus_we; h_wdata = bus_wdata;
            if (wait_cnt >= ack_delay) begin
                bus_ack = 1'b1; txn++; held = 0;
                if (bus_we) tmem[bus_addr[12:2]] = bus_wdata;
                else        bus_rdata = tmem[bus_addr[12:2]];
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic csr_write(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [63:0] v);
        csr_addr = a;
        #1 v = csr_rdata;
    endtask

    task automatic csr_read(input logic [7:0] a, output logic [63:0] v);
        @(negedge clk);
        peek(a, v);
    endtask

    task automatic wait_done(output int polls);
        logic [63:0] v;
        polls = 0;
        do begin
            csr_read(8'h18, v);
            polls++;
        end while (!v[32] && polls < 100);
    endtask

    // one full access, checked against the shadow memory
    task automatic access(input bit wr, input logic [10:0] w, input logic [31:0] d);
        logic [63:0] v;
        int polls, t0;
        t0 = txn;
        csr_write(8'h10, cmd(wr ? 2'd2 : 2'd1, {w, 2'b00}, d));
        peek(8'h18, v);
        check("R5 done cleared", 64'(v[32]), 64'd0);
        wait_done(polls);
        check("R11 polls bound", 64'(polls <= 10), 64'd1);
        csr_read(8'h18, v);
        if (wr) emem[w] = d;
        else    exp_rd = emem[w];
        check("R5 done set", 64'(v[32]), 64'd1);
        check(wr ? "R6 write keeps data" : "R3 read data", 64'(v[31:0]), 64'(exp_rd));
        check("R3 one transaction", 64'(txn - t0), 64'd1);
    endtask

    initial begin
        logic [63:0] v;
        int polls, t0;
        for (int i = 0; i < 2048; i++) begin
            tmem[i] = 32'hA5000000 ^ (i * 32'h9E37);
            emem[i] = 32'hA5000000 ^ (i * 32'h9E37);
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        peek(8'h18, v);
        check("R10 status reset", v, 64'd0);
        check("R10 no request", 64'(bus_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        csr_read(8'h08, v);
        check("R1 descriptor", v, exp_desc());
        csr_read(8'h10, v);
        check("R2 control reads zero", v, 64'd0);
        csr_read(8'h00, v);
        check("R2 offset 0 reads zero", v, 64'd0);
        csr_read(8'h20, v);
        check("R2 offset 0x20 reads zero", v, 64'd0);

        access(1'b0, 11'd5, 32'd0);
        access(1'b1, 11'd2047, 32'hDEADBEEF);
        access(1'b0, 11'd2047, 32'd0);
        access(1'b1, 11'd0, 32'h0000_0001);

        for (int k = 0; k < 40; k++) begin
            ack_delay = int'($urandom_range(0, 3));
            access(1'($urandom_range(0, 1)), 11'($urandom_range(0, 2047)), $urandom);
        end

        // R9: writes to read-only words
        csr_write(8'h08, 64'hFFFF_FFFF_FFFF_FFFF);
        csr_read(8'h08, v);
        check("R9 descriptor unchanged", v, exp_desc());
        csr_write(8'h18, 64'h0);
        csr_read(8'h18, v);
        check("R9 status unchanged", v, {31'd0, 1'b1, exp_rd});

        // R7: idle and unused opcodes
        t0 = txn;
        csr_write(8'h10, cmd(2'd0, 13'h40, 32'h1111));
        csr_read(8'h18, v);
        check("R7 opcode 0 status", v, {31'd0, 1'b1, exp_rd});
        csr_write(8'h10, cmd(2'd3, 13'h40, 32'h2222));
        repeat (3) @(negedge clk);
        csr_read(8'h18, v);
        check("R7 opcode 3 status", v, {31'd0, 1'b1, exp_rd});
        check("R7 no transaction", 64'(txn - t0), 64'd0);

        // R8: second command while busy is dropped
        ack_delay = 6;
        t0 = txn;
        csr_write(8'h10, cmd(2'd1, 13'h0C8, 32'd0));
        csr_write(8'h10, cmd(2'd2, 13'h0CC, 32'h5555_AAAA));
        csr_write(8'h10, cmd(2'd1, 13'h100, 32'd0));
        wait_done(polls);
        repeat (4) @(negedge clk);
        check("R8 single access", 64'(txn - t0), 64'd1);
        csr_read(8'h18, v);
        check("R8 first read data", 64'(v[31:0]), 64'(emem[11'h32]));
        exp_rd = emem[11'h32];
        ack_delay = 0;
        access(1'b0, 11'h33, 32'd0);
        check("R8 dropped write absent", 64'(exp_rd), 64'(emem[11'h33]));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule